// File: doc/BRIEF.md
# Periodic and One-Shot Timer Comparator Channel

This block is one comparator channel of an event timer. A shared main counter elsewhere supplies its current value, a run flag and a one-cycle step strobe marking the cycle in which a fresh counter value is presented. The channel holds a comparator register and raises a status bit when the counter value equals that register. From the status bit and the channel configuration it produces either a level interrupt or a single-cycle interrupt pulse.

The channel runs in one of two modes. In one-shot mode the comparator keeps whatever software last wrote. In periodic mode the hardware moves the comparator forward after each match by a stored period. The stored period is a copy of the most recent software write to the comparator, kept apart from the live comparator value. Software writes configuration or comparator through one write port and clears status with a separate strobe.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, `sts` and `irq` are 0, `cmp_out` is all ones and the configuration is all zero (one-shot, interrupt disabled, pulse output).
- R2: A match happens in a cycle with `cnt_run`=1, `cnt_tick`=1 and `cnt_val` equal to the comparator; `sts` reads 1 after that clock edge.
- R3: In one-shot mode (config bit 3 = 0) the hardware never changes the comparator; it changes only on a software comparator write.
- R4: In periodic mode (config bit 3 = 1) every match adds the stored period to the comparator, modulo 2^CNT_W, with the result visible after the matching edge.
- R5: A write with `wr_sel`=1 loads `wr_data` into both the comparator and the stored period; a write in the same cycle as a periodic match takes priority over the advance.
- R6: A write with `wr_sel`=0 loads configuration: bit 1 selects level output, bit 2 enables the interrupt, bit 3 selects periodic mode; every other bit of `wr_data` is ignored.
- R7: In level mode (bit 1 = 1) `irq` equals `sts` AND the interrupt enable, and stays high until status is cleared.
- R8: In pulse mode (bit 1 = 0) with the interrupt enabled, `irq` is high for exactly the one cycle after each matching edge.
- R9: `sts_clr` clears `sts` at the next edge; a match in the same cycle wins and leaves `sts` at 1.
- R10: With the interrupt disabled (bit 2 = 0) a match still sets `sts` but `irq` stays 0.
- R11: No match occurs while `cnt_run` is 0 or `cnt_tick` is 0, even when `cnt_val` equals the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current main counter value |
| cnt_run | input | 1 | Main counter enable |
| cnt_tick | input | 1 | One cycle per counter increment; qualifies matching |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 comparator |
| wr_data | input | CNT_W | Write data |
| sts_clr | input | 1 | Status clear strobe |
| irq | output | 1 | Interrupt, level or pulse per configuration |
| sts | output | 1 | Match status |
| cmp_out | output | CNT_W | Live comparator value |

## Verification
Every result is due one clock edge after the cycle holding its stimulus: status, comparator advance, comparator and configuration loads, and the interrupt pulse all come from registers, while the level interrupt follows status combinationally and so appears at the same edge. The bench changes inputs just after a rising edge and samples outputs just after the next one, so each check sees exactly the edge its stimulus reached. A pulse-mode interrupt is checked high after the matching edge and low after the following one. In the random phase a bench model steps once per edge on the same inputs and is compared every cycle.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

    // Configuration field positions inside a configuration write
    localparam int CFG_LVL_BIT = 1;
    localparam int CFG_IEN_BIT = 2;
    localparam int CFG_PER_BIT = 3;
    localparam int CFG_FIELDS  = 3;

    typedef enum logic {
        SEL_CFG = 1'b0,
        SEL_CMP = 1'b1
    } wr_sel_e;

    typedef struct packed {
        logic periodic;
        logic irq_en;
        logic level;
    } chan_cfg_t;

    typedef struct packed {
        logic hit;
        logic advance;
    } match_ev_t;

    localparam chan_cfg_t CFG_RESET = '{periodic: 1'b0, irq_en: 1'b0, level: 1'b0};

    // Fields arrive packed as {periodic, irq_en, level}
    function automatic chan_cfg_t cfg_decode(input logic [CFG_FIELDS-1:0] f);
        chan_cfg_t c;
        c.periodic = f[2];
        c.irq_en   = f[1];
        c.level    = f[0];
        return c;
    endfunction

    function automatic match_ev_t match_eval(input logic run, input logic tick,
                                             input logic equal, input logic periodic);
        match_ev_t m;
        m.hit     = run & tick & equal;
        m.advance = m.hit & periodic;
        return m;
    endfunction

endpackage

// File: rtl/cmp_cfg_reg.sv
module cmp_cfg_reg
    import evt_cmp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_cfg,
    input  logic [CFG_FIELDS-1:0] wr_fields,
    output chan_cfg_t             cfg_o
);

    chan_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_cfg) begin
            cfg_q <= cfg_decode(wr_fields);
        end
    end

    assign cfg_o = cfg_q;

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(cfg_q));

endmodule

// File: rtl/cmp_value_unit.sv
module cmp_value_unit
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_run,
    input  logic             cnt_tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cmp_o,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] CMP_RESET = '1;
    localparam logic [CNT_W-1:0] PER_RESET = '0;

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cmp_next_sum;
    match_ev_t        ev;

    always_comb begin
        ev           = match_eval(cnt_run, cnt_tick, cnt_val == cmp_q, periodic);
        cmp_next_sum = cmp_q + per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= CMP_RESET;
            per_q <= PER_RESET;
        end else if (wr_cmp) begin
            cmp_q <= wr_data;
            per_q <= wr_data;
        end else if (ev.advance) begin
            cmp_q <= cmp_next_sum;
        end
    end

    assign cmp_o = cmp_q;
    assign hit_o = ev.hit;

    // R3
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!periodic && !wr_cmp) |=> $stable(cmp_q));

    // R4
    periodic_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && periodic && !wr_cmp) |=> (cmp_q == $past(cmp_q) + $past(per_q)));

    // R5
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmp |=> (cmp_q == $past(wr_data) && per_q == $past(wr_data)));

    // R5
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cmp |=> $stable(per_q));

endmodule

// File: rtl/cmp_irq_gen.sv
module cmp_irq_gen
    import evt_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  logic      sts_clr,
    input  chan_cfg_t cfg,
    output logic      sts_o,
    output logic      irq_o
);

    logic sts_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (hit) begin
                sts_q <= 1'b1;
            end else if (sts_clr) begin
                sts_q <= 1'b0;
            end
            pulse_q <= hit & cfg.irq_en & ~cfg.level;
        end
    end

    always_comb begin
        if (cfg.level) begin
            irq_o = sts_q & cfg.irq_en;
        end else begin
            irq_o = pulse_q;
        end
    end

    assign sts_o = sts_q;

    // R9
    hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> sts_q);

    // R9
    clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !hit) |=> !sts_q);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(hit));

    // R10
    pulse_gated_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(cfg.irq_en));

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_run,
    input  logic             cnt_tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sts_clr,
    output logic             irq,
    output logic             sts,
    output logic [CNT_W-1:0] cmp_out
);

    wr_sel_e               sel;
    logic                  wr_cfg;
    logic                  wr_cmp;
    logic [CFG_FIELDS-1:0] cfg_fields;
    chan_cfg_t             cfg;
    logic                  hit;

    always_comb begin
        sel        = wr_sel_e'(wr_sel);
        wr_cfg     = wr_en && (sel == SEL_CFG);
        wr_cmp     = wr_en && (sel == SEL_CMP);
        cfg_fields = {wr_data[CFG_PER_BIT], wr_data[CFG_IEN_BIT], wr_data[CFG_LVL_BIT]};
    end

    cmp_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (wr_cfg),
        .wr_fields (cfg_fields),
        .cfg_o     (cfg)
    );

    cmp_value_unit #(.CNT_W(CNT_W)) u_val (
        .clk      (clk),
        .rst      (rst),
        .wr_cmp   (wr_cmp),
        .wr_data  (wr_data),
        .cnt_val  (cnt_val),
        .cnt_run  (cnt_run),
        .cnt_tick (cnt_tick),
        .periodic (cfg.periodic),
        .cmp_o    (cmp_out),
        .hit_o    (hit)
    );

    cmp_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .sts_clr (sts_clr),
        .cfg     (cfg),
        .sts_o   (sts),
        .irq_o   (irq)
    );

    // R11
    idle_counter_chk: assert property (@(posedge clk) disable iff (rst)
        ((!cnt_run || !cnt_tick) && !sts_clr) |=> $stable(sts));

    // R2
    match_status_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_run && cnt_tick && cnt_val == cmp_out) |=> sts);

endmodule

// File: tb/evt_cmp_channel_test.sv
module evt_cmp_channel_test;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_run = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         sts_clr = 1'b0;
    logic         irq;
    logic         sts;
    logic [W-1:0] cmp_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] m_cmp, m_per;
    logic m_per_mode, m_ien, m_lvl, m_sts, m_pulse;

    always #10 clk = ~clk;

    evt_cmp_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_run(cnt_run),
        .cnt_tick(cnt_tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sts_clr(sts_clr), .irq(irq), .sts(sts), .cmp_out(cmp_out)
    );

    function automatic logic exp_irq();
        return m_lvl ? (m_sts & m_ien) : m_pulse;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one edge, stepping the model on the inputs seen at that edge
    task automatic tick();
        logic hit;
        hit = cnt_run && cnt_tick && (cnt_val == m_cmp);
        if (rst) begin
            m_cmp = '1; m_per = '0; m_per_mode = 0; m_ien = 0; m_lvl = 0;
            m_sts = 0; m_pulse = 0;
        end else begin
            m_pulse = hit && m_ien && !m_lvl;
            if (hit) m_sts = 1'b1;
            else if (sts_clr) m_sts = 1'b0;
            if (wr_en && wr_sel) begin
                m_cmp = wr_data; m_per = wr_data;
            end else if (hit && m_per_mode) begin
                m_cmp = m_cmp + m_per;
            end
            if (wr_en && !wr_sel) begin
                m_lvl = wr_data[1]; m_ien = wr_data[2]; m_per_mode = wr_data[3];
            end
        end
        @(posedge clk);
        #1;
        wr_en = 0; sts_clr = 0; cnt_tick = 0;
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
    endtask

    task automatic hit_at(input logic [W-1:0] v);
        cnt_val = v; cnt_run = 1; cnt_tick = 1;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] cnt;
        int r;
        r = $urandom(32'h5eed);
        #1;
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        chk("R1 sts", sts, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cmp", cmp_out, '1);

        // level, enabled, one-shot
        wr(0, 64'h6); tick();
        wr(1, 64'd10); tick();
        chk("R5 cmp load", cmp_out, 64'd10);
        hit_at(64'd9); tick();
        chk("R2 no equal", sts, 0);
        hit_at(64'd10); cnt_run = 0; tick();
        chk("R11 run low", sts, 0);
        hit_at(64'd10); cnt_tick = 0; tick();
        chk("R11 tick low", sts, 0);
        hit_at(64'd10); tick();
        chk("R2 match sts", sts, 1);
        chk("R7 level irq", irq, 1);
        chk("R3 one-shot hold", cmp_out, 64'd10);
        tick();
        chk("R7 level stays", irq, 1);
        hit_at(64'd11); tick();
        chk("R3 one-shot later", cmp_out, 64'd10);
        sts_clr = 1; tick();
        chk("R9 clear sts", sts, 0);
        chk("R9 clear irq", irq, 0);
        hit_at(64'd10); sts_clr = 1; tick();
        chk("R9 match wins", sts, 1);

        // level, disabled
        wr(0, 64'h2); sts_clr = 1; tick();
        hit_at(64'd10); tick();
        chk("R10 sts sets", sts, 1);
        chk("R10 irq quiet", irq, 0);

        // pulse, enabled, periodic
        wr(0, 64'hC); sts_clr = 1; tick();
        wr(1, 64'd100); tick();
        hit_at(64'd100); tick();
        chk("R8 pulse high", irq, 1);
        chk("R4 advance", cmp_out, 64'd200);
        tick();
        chk("R8 pulse low", irq, 0);
        chk("R8 sts kept", sts, 1);
        hit_at(64'd150); tick();
        chk("R4 no early adv", cmp_out, 64'd200);
        hit_at(64'd200); tick();
        chk("R4 second adv", cmp_out, 64'd300);
        chk("R8 second pulse", irq, 1);

        // wrap modulo 2^64
        wr(1, 64'hFFFF_FFFF_FFFF_FFFB); tick();
        hit_at(64'hFFFF_FFFF_FFFF_FFFB); tick();
        chk("R4 wrap", cmp_out, 64'hFFFF_FFFF_FFFF_FFF6);

        // write beats advance
        hit_at(64'hFFFF_FFFF_FFFF_FFF6); wr(1, 64'd555); tick();
        chk("R5 write wins", cmp_out, 64'd555);
        chk("R5 match sts", sts, 1);
        hit_at(64'd555); tick();
        chk("R5 new period", cmp_out, 64'd1110);

        // ignored config bits: 0xF1 leaves level, enable and periodic clear
        wr(0, 64'hFFFF_FFFF_FFFF_FFF1); tick();
        sts_clr = 1; tick();
        hit_at(64'd1110); tick();
        chk("R6 ignored bits irq", irq, 0);
        chk("R6 ignored bits cmp", cmp_out, 64'd1110);
        wr(0, 64'hE); tick();
        chk("R6 level enable", irq, 1);

        // constrained random phase against the bench model
        cnt = 64'd5000;
        for (int c = 0; c < 3000; c++) begin
            cnt_val = cnt;
            cnt_run = ($urandom % 8) != 0;
            cnt_tick = ($urandom % 2) != 0;
            sts_clr = ($urandom % 10) == 0;
            if (($urandom % 12) == 0) begin
                if (($urandom % 2) != 0) wr(1, cnt + 64'(1 + $urandom % 6));
                else wr(0, 64'($urandom % 16));
            end
            if (cnt_run && cnt_tick) cnt = cnt + 1;
            tick();
            chk("R2 rand sts", sts, m_sts);
            chk("R7 rand irq", irq, exp_irq());
            chk("R4 rand cmp", cmp_out, m_cmp);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule